// File: doc/BRIEF.md
# Interrupt Entry Stacking Sequencer

This block carries out the hardware half of taking an interrupt on a small 16-bit processor with a 20-bit program counter. When the interrupt controller raises a request and the block is idle, the block accepts it in that cycle. It copies the live program counter, flag word and stack pointer, and it sets the processor interrupt priority level according to the class of the source. It then writes a four-byte frame below the old stack pointer, one byte per clock, through a simple memory write port.

Once the last byte is written, the block raises a one-cycle done pulse and presents the lowered stack pointer. Only the flag word and the program counter reach the stack. The first 16-bit item packs the top four PC bits with the flag word's upper nibble and its low byte. The second item is PC[15:0], and it is written after the first. Vector fetch, return from interrupt and any saving of general registers belong elsewhere.

Top module: `intr_entry_stacker`

## Requirements
- R1: `ack` is high in exactly those cycles where `req` is high and no entry is in progress. That cycle is the acknowledge cycle.
- R2: The source class is encoded on `src_class`. For class 0 (the source carries a level), `ipl` equals the `req_level` sampled in the acknowledge cycle, from the following cycle on.
- R3: For class 1 (watchdog or non-maskable source), `ipl` becomes 7 in the cycle after acknowledge.
- R4: For class 2 (reset-type source), `ipl` becomes 0 in the cycle after acknowledge.
- R5: For class 3 (any other source without a level), `ipl` keeps its prior value.
- R6: Let m be the SP sampled at acknowledge. The frame is written in four back-to-back cycles that start the cycle after acknowledge, one byte per cycle with `mem_we` high. The writes go in this order:
  - first, address m-1 receives {FLG[15:12], PC[19:16]};
  - second, address m-2 receives FLG[7:0];
  - third, address m-3 receives PC[15:8];
  - fourth, address m-4 receives PC[7:0].
  All addresses are taken modulo 2^ADDR_W.
- R7: Each entry makes no writes other than those four, so bytes at m and above keep their contents. `mem_we` is low outside the write cycles.
- R8: `done` is high for exactly one cycle, the cycle after the fourth write. From then on `new_sp` holds m-4 modulo 2^ADDR_W.
- R9: Changes to `src_class`, `req_level`, `cur_pc`, `cur_flg` or `cur_sp` after the acknowledge cycle have no effect on the frame, `ipl` or `new_sp` of that entry.
- R10: A request held or raised while an entry is in progress (write cycles and the done cycle) is not acknowledged.
- R11: Synchronous reset returns the block to idle with `ipl` = 0, `new_sp` = 0, `mem_we` = 0 and `done` = 0, including when reset arrives mid-frame. No further writes of the aborted frame follow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req | input | 1 | Interrupt request from the controller |
| ack | output | 1 | Request accepted this cycle |
| src_class | input | 2 | Source class: 0 leveled, 1 watchdog/NMI, 2 reset, 3 other |
| req_level | input | IPL_W | Priority level of a leveled request |
| cur_pc | input | 20 | Program counter at acknowledge |
| cur_flg | input | 16 | Flag word at acknowledge |
| cur_sp | input | ADDR_W | Stack pointer at acknowledge |
| mem_we | output | 1 | Byte write strobe |
| mem_addr | output | ADDR_W | Byte write address |
| mem_wdata | output | 8 | Byte write data |
| new_sp | output | ADDR_W | Stack pointer after the last completed entry |
| ipl | output | IPL_W | Processor interrupt priority level |
| done | output | 1 | One-cycle pulse when the frame is complete |

## Verification
The bench drives every source class in a directed order so that each IPL rule is separated from the others. In particular, a "keep" class that follows a leveled one or a forced-7 one shows that the previous level really survives. Stack pointers of 0 and 2 force the frame across the bottom of the address space, which exposes any address arithmetic that fails to wrap. Random entries with random PC, flag and SP values show that no bit of the frame is misrouted between byte slots. About half of them also scramble every input and hold the request high during the sequence, which separates a true acknowledge-time snapshot from live input use and shows that busy requests are ignored. A reset in the middle of a frame shows that the aborted frame stops writing.

// File: rtl/intr_stack_pkg.sv
package intr_stack_pkg;

    localparam int PC_W  = 20;
    localparam int FLG_W = 16;
    localparam int FRAME_BYTES = 4;

    typedef enum logic [1:0] {
        SRC_LEVELED   = 2'd0,
        SRC_FORCE_TOP = 2'd1,
        SRC_RESET     = 2'd2,
        SRC_KEEP      = 2'd3
    } src_class_e;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_PUSH = 2'd1,
        PH_DONE = 2'd2
    } phase_e;

endpackage

// File: rtl/ipl_rule.sv
module ipl_rule
    import intr_stack_pkg::*;
#(
    parameter int IPL_W = 3
) (
    input  logic [1:0]       src_class,
    input  logic [IPL_W-1:0] req_level,
    input  logic [IPL_W-1:0] cur_ipl,
    output logic [IPL_W-1:0] nxt_ipl
);

    always_comb begin
        case (src_class_e'(src_class))
            SRC_LEVELED:   nxt_ipl = req_level;
            SRC_FORCE_TOP: nxt_ipl = '1;
            SRC_RESET:     nxt_ipl = '0;
            default:       nxt_ipl = cur_ipl;
        endcase
    end

endmodule

// File: rtl/frame_byte_sel.sv
module frame_byte_sel
    import intr_stack_pkg::*;
(
    input  logic [1:0]       slot,
    input  logic [PC_W-1:0]  pc,
    input  logic [FLG_W-1:0] flg,
    output logic [7:0]       byte_out
);

    // Slot order follows the write order: high item first, then PC low word.
    always_comb begin
        case (slot)
            2'd0:    byte_out = {flg[FLG_W-1 -: 4], pc[PC_W-1 -: 4]};
            2'd1:    byte_out = flg[7:0];
            2'd2:    byte_out = pc[15:8];
            default: byte_out = pc[7:0];
        endcase
    end

endmodule

// File: rtl/intr_entry_stacker.sv
module intr_entry_stacker
    import intr_stack_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int IPL_W  = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req,
    output logic              ack,
    input  logic [1:0]        src_class,
    input  logic [IPL_W-1:0]  req_level,
    input  logic [PC_W-1:0]   cur_pc,
    input  logic [FLG_W-1:0]  cur_flg,
    input  logic [ADDR_W-1:0] cur_sp,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [7:0]        mem_wdata,
    output logic [ADDR_W-1:0] new_sp,
    output logic [IPL_W-1:0]  ipl,
    output logic              done
);

    localparam int SLOT_W = $clog2(FRAME_BYTES);
    localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(FRAME_BYTES - 1);
    localparam logic [ADDR_W-1:0] ONE       = ADDR_W'(1);
    localparam logic [ADDR_W-1:0] FRAME_SZ  = ADDR_W'(FRAME_BYTES);

    typedef struct packed {
        phase_e             phase;
        logic [SLOT_W-1:0]  slot;
        logic [PC_W-1:0]    pc;
        logic [FLG_W-1:0]   flg;
        logic [ADDR_W-1:0]  sp;
        logic [ADDR_W-1:0]  sp_out;
        logic [IPL_W-1:0]   ipl;
    } state_t;

    state_t st_d, st_q;
    logic [IPL_W-1:0] ipl_pick;
    logic             take;

    ipl_rule #(.IPL_W(IPL_W)) i_ipl_rule (
        .src_class (src_class),
        .req_level (req_level),
        .cur_ipl   (st_q.ipl),
        .nxt_ipl   (ipl_pick)
    );

    frame_byte_sel i_frame_byte_sel (
        .slot     (st_q.slot),
        .pc       (st_q.pc),
        .flg      (st_q.flg),
        .byte_out (mem_wdata)
    );

    always_comb begin
        st_d = st_q;
        take = req && (st_q.phase == PH_IDLE);
        case (st_q.phase)
            PH_IDLE: begin
                if (take) begin
                    st_d.phase = PH_PUSH;
                    st_d.slot  = '0;
                    st_d.pc    = cur_pc;
                    st_d.flg   = cur_flg;
                    st_d.sp    = cur_sp;
                    st_d.ipl   = ipl_pick;
                end
            end
            PH_PUSH: begin
                st_d.slot = st_q.slot + 1'b1;
                if (st_q.slot == LAST_SLOT) begin
                    st_d.phase  = PH_DONE;
                    st_d.sp_out = st_q.sp - FRAME_SZ;
                end
            end
            default: begin
                st_d.phase = PH_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign ack      = take;
    assign mem_we   = (st_q.phase == PH_PUSH);
    assign mem_addr = st_q.sp - ONE - ADDR_W'(st_q.slot);
    assign done     = (st_q.phase == PH_DONE);
    assign new_sp   = st_q.sp_out;
    assign ipl      = st_q.ipl;

endmodule

// File: rtl/intr_entry_stacker_chk.sv
module intr_entry_stacker_chk #(
    parameter int ADDR_W = 16,
    parameter int IPL_W  = 3
) (
    input logic              clk,
    input logic              rst,
    input logic              req,
    input logic              ack,
    input logic [1:0]        src_class,
    input logic [IPL_W-1:0]  req_level,
    input logic              mem_we,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [ADDR_W-1:0] new_sp,
    input logic [IPL_W-1:0]  ipl,
    input logic              done
);

    // R1
    ack_needs_req_chk: assert property (@(posedge clk) disable iff (rst)
        ack |-> req);

    // R10
    no_ack_when_busy_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_we || done) |-> !ack);

    // R2
    level_loaded_chk: assert property (@(posedge clk) disable iff (rst)
        (ack && src_class == 2'd0) |=> (ipl == $past(req_level)));

    // R3
    force_top_chk: assert property (@(posedge clk) disable iff (rst)
        (ack && src_class == 2'd1) |=> (ipl == '1));

    // R4
    reset_class_chk: assert property (@(posedge clk) disable iff (rst)
        (ack && src_class == 2'd2) |=> (ipl == '0));

    // R5
    keep_class_chk: assert property (@(posedge clk) disable iff (rst)
        (ack && src_class == 2'd3) |=> $stable(ipl));

    // R6
    addr_descends_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_we && $past(mem_we)) |-> (mem_addr == $past(mem_addr) - 1'b1));

    // R6
    write_follows_ack_chk: assert property (@(posedge clk) disable iff (rst)
        ack |=> mem_we);

    // R8
    done_after_write_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> ($past(mem_we) && !mem_we));

    // R8
    done_single_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R8
    sp_matches_last_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> (new_sp == $past(mem_addr)));

    // R11
    reset_clears_chk: assert property (@(posedge clk)
        $past(rst) |-> (ipl == '0 && !mem_we && !done && new_sp == '0));

endmodule

bind intr_entry_stacker intr_entry_stacker_chk #(
    .ADDR_W (ADDR_W),
    .IPL_W  (IPL_W)
) i_chk (
    .clk       (clk),
    .rst       (rst),
    .req       (req),
    .ack       (ack),
    .src_class (src_class),
    .req_level (req_level),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .new_sp    (new_sp),
    .ipl       (ipl),
    .done      (done)
);

// File: tb/test_intr_entry_stacker.sv
`timescale 1ns/1ps
module test_intr_entry_stacker;

    localparam int ADDR_W = 16;
    localparam int IPL_W  = 3;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              req = 1'b0;
    logic              ack;
    logic [1:0]        src_class = '0;
    logic [IPL_W-1:0]  req_level = '0;
    logic [19:0]       cur_pc = '0;
    logic [15:0]       cur_flg = '0;
    logic [ADDR_W-1:0] cur_sp = '0;
    logic              mem_we;
    logic [ADDR_W-1:0] mem_addr;
    logic [7:0]        mem_wdata;
    logic [ADDR_W-1:0] new_sp;
    logic [IPL_W-1:0]  ipl;
    logic              done;

    int n_chk  = 0;
    int n_fail = 0;
    logic [IPL_W-1:0] ipl_m = '0;

    always #2 clk = ~clk;

    intr_entry_stacker #(.ADDR_W(ADDR_W), .IPL_W(IPL_W)) i_intr_entry_stacker (
        .clk(clk), .rst(rst), .req(req), .ack(ack), .src_class(src_class),
        .req_level(req_level), .cur_pc(cur_pc), .cur_flg(cur_flg), .cur_sp(cur_sp),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .new_sp(new_sp), .ipl(ipl), .done(done)
    );

    task automatic chk(input logic ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [7:0] exp_byte(input int k, input logic [19:0] pc,
                                            input logic [15:0] flg);
        case (k)
            0: return {flg[15:12], pc[19:16]};
            1: return flg[7:0];
            2: return pc[15:8];
            default: return pc[7:0];
        endcase
    endfunction

    function automatic logic [IPL_W-1:0] exp_ipl(input logic [1:0] cls,
            input logic [IPL_W-1:0] lvl, input logic [IPL_W-1:0] cur);
        case (cls)
            2'd0: return lvl;
            2'd1: return '1;
            2'd2: return '0;
            default: return cur;
        endcase
    endfunction

    // One complete entry; perturb scrambles inputs and holds req during the sequence.
    task automatic run_entry(input logic [1:0] cls, input logic [IPL_W-1:0] lvl,
                             input logic [19:0] pc, input logic [15:0] flg,
                             input logic [ADDR_W-1:0] sp, input bit perturb);
        logic [ADDR_W-1:0] a;
        @(negedge clk);
        src_class = cls; req_level = lvl; cur_pc = pc; cur_flg = flg; cur_sp = sp;
        req = 1'b1;
        #0.1;
        chk(ack === 1'b1, "R1 ack when idle", 32'(ack), 1);
        ipl_m = exp_ipl(cls, lvl, ipl_m);
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            if (perturb) begin
                src_class = 2'($urandom); req_level = IPL_W'($urandom);
                cur_pc = 20'($urandom); cur_flg = 16'($urandom); cur_sp = 16'($urandom);
            end else begin
                req = 1'b0;
            end
            #0.1;
            a = sp - ADDR_W'(k + 1);
            chk(mem_we === 1'b1, "R6 we in write cycle", 32'(mem_we), 1);
            chk(mem_addr === a, "R6 address", 32'(mem_addr), 32'(a));
            chk(mem_wdata === exp_byte(k, pc, flg), "R6/R9 byte", 32'(mem_wdata),
                32'(exp_byte(k, pc, flg)));
            chk(ack === 1'b0, "R10 no ack while busy", 32'(ack), 0);
            chk(done === 1'b0, "R8 no early done", 32'(done), 0);
        end
        @(negedge clk);
        #0.1;
        chk(done === 1'b1, "R8 done pulse", 32'(done), 1);
        chk(mem_we === 1'b0, "R7 no fifth write", 32'(mem_we), 0);
        chk(new_sp === ADDR_W'(sp - 4), "R8 new sp", 32'(new_sp), 32'(ADDR_W'(sp - 4)));
        chk(ipl === ipl_m, "R2-5 ipl rule (R2 R3 R4 R5)", 32'(ipl), 32'(ipl_m));
        chk(ack === 1'b0, "R10 no ack in done cycle", 32'(ack), 0);
        req = 1'b0;
        @(negedge clk);
        #0.1;
        chk(done === 1'b0, "R8 done one cycle", 32'(done), 0);
        chk(mem_we === 1'b0, "R7 idle no write", 32'(mem_we), 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        void'($urandom(32'd4711));
        repeat (3) @(negedge clk);
        #0.1;
        chk(ipl === '0 && new_sp === '0, "R11 reset state", {ipl, new_sp}, 0);
        chk(mem_we === 1'b0 && done === 1'b0, "R11 reset quiet", {mem_we, done}, 0);
        rst = 1'b0;

        run_entry(2'd0, 3'd5, 20'hA1234, 16'hC3F5, 16'h8000, 1'b0); // R2
        run_entry(2'd3, 3'd1, 20'h5BCDE, 16'h1E0A, 16'h7FFC, 1'b0); // R5 keeps 5
        run_entry(2'd1, 3'd2, 20'hF0F0F, 16'h9999, 16'h4000, 1'b0); // R3
        run_entry(2'd3, 3'd0, 20'h00001, 16'hFFFF, 16'h1234, 1'b1); // R5 keeps 7
        run_entry(2'd2, 3'd6, 20'h3C3C3, 16'hA5A5, 16'h2222, 1'b1); // R4
        run_entry(2'd0, 3'd3, 20'hFFFFF, 16'h0F00, 16'h0000, 1'b0); // R6 wrap at 0
        run_entry(2'd0, 3'd4, 20'h12345, 16'h6789, 16'h0002, 1'b1); // R6 wrap at 2

        // R11 reset mid-frame
        @(negedge clk);
        src_class = 2'd1; cur_sp = 16'h0100; req = 1'b1;
        @(negedge clk);
        req = 1'b0;
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        #0.1;
        rst = 1'b0;
        ipl_m = '0;
        chk(ipl === '0 && new_sp === '0, "R11 mid-frame reset state", {ipl, new_sp}, 0);
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            #0.1;
            chk(mem_we === 1'b0 && done === 1'b0, "R11 aborted frame silent",
                {mem_we, done}, 0);
        end

        for (int i = 0; i < 60; i++) begin
            run_entry(2'($urandom), IPL_W'($urandom), 20'($urandom), 16'($urandom),
                      16'($urandom), bit'($urandom));
        end

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule